// File: doc/BRIEF.md
# Oversampled Serial Word Gearbox

The block lets a serializer/deserializer that runs at a fixed serial rate carry a line signal four times slower. Each line bit is sent as four identical serial samples. On the transmit side, two line bits are accepted per parallel clock. Each bit is widened into four copies, which gives an 8-bit word for the serializer. On the receive side, 8-bit sample words from the deserializer are reduced back to two line bits each. With a 77.76 MHz parallel clock and a 622.08 Mb/s serial rate, the link carries a 155.52 Mb/s line signal.

The receive side decides each group of four samples by majority. A 2-2 tie is resolved to the bit decided just before it, and a running tie count shows link quality. A phase input slides the four-sample grouping by zero to three samples. A one-word history register supplies the samples that a shifted group borrows from the previous word. Both paths use a single-cycle valid strobe, and the transmit side also raises a ready flag.

The reset input is asynchronous and active-low. It is released synchronously through a two-stage synchronizer, so the block leaves reset two clock edges after the reset input rises.

Top module: `ovs_gearbox`

## Requirements
- R1: While reset is active, `tx_word_o` is all zeros, and `tx_word_valid_o`, `tx_ready_o` and `rx_valid_o` are low. The reset also clears the tie count, the receive history word and the last decided bit to zero.
- R2: A transmit beat (`tx_valid_i` high while `tx_ready_o` is high) appears one cycle later with `tx_word_valid_o` high. Bit `tx_bits_i[1]` is the earlier line bit and fills `tx_word_o[7:4]`. Bit `tx_bits_i[0]` fills `tx_word_o[3:0]`. For example, bits 2'b01 give 8'h0F.
- R3: Outside reset, `tx_ready_o` is high on every cycle. A cycle without a beat gives `tx_word_valid_o` low on the next cycle, and `tx_word_o` keeps its last value.
- R4: Every accepted receive word (`rx_valid_i` high) gives exactly one `rx_valid_o` pulse one cycle later. With phase 0, `rx_bits_o[1]` is decided from `rx_word_i[7:4]` and `rx_bits_o[0]` from `rx_word_i[3:0]`. For example, 8'hF0 gives 2'b10.
- R5: A group with three or four ones decides 1. A group with zero or one ones decides 0.
- R6: A group with exactly two ones decides the previously decided bit. For the earlier group this is the later bit of the previous accepted word, or 0 after reset. For the later group it is the earlier group's result. `rx_tie_cnt_o` rises by the number of tied groups in the word, modulo 2^16.
- R7: With phase p, the sample window is bits [7+p:p] of the 16-bit stream {previous accepted word, current word}. Bit 15 is the earliest sample. The earlier group is taken from window bits [7:4] and the later group from window bits [3:0].
- R8: A receive word presented with `rx_valid_i` low is ignored. It gives no `rx_valid_o` pulse and does not change the history word, the last decided bit or the tie count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_valid_i | input | 1 | Transmit beat offered |
| tx_bits_i | input | 2 | Two line bits; bit 1 is the earlier |
| tx_ready_o | output | 1 | Transmit beat can be taken |
| tx_word_o | output | 8 | Replicated word for the serializer; bit 7 is sent first |
| tx_word_valid_o | output | 1 | `tx_word_o` carries a new beat |
| rx_valid_i | input | 1 | Deserializer sample word present |
| rx_word_i | input | 8 | Sample word; bit 7 is the earliest sample |
| rx_phase_i | input | 2 | Group offset in samples, 0 to 3 |
| rx_valid_o | output | 1 | `rx_bits_o` carries a new decision |
| rx_bits_o | output | 2 | Decided line bits; bit 1 is the earlier |
| rx_tie_cnt_o | output | 16 | Count of 2-2 tie decisions |

## Verification
The hardest case to reach from the ports is a shifted group that straddles two words. The result then depends on the trailing samples of the previous accepted word and on the last decided bit. It must not depend on any word presented while `rx_valid_i` was low. The bench first primes the history with a known word and then presents a conflicting word with the valid strobe low. It then sends a word at phase 3, and the expected bits differ depending on which of the two words fed the history. Ties are produced on purpose with words whose groups carry two ones, including chains where the later group inherits a tied earlier result. These runs are repeated across a mid-run reset to show that the inherited bit returns to 0.

// File: rtl/ovs_gearbox_pkg.sv
package ovs_gearbox_pkg;
  typedef enum logic [1:0] {
    VOTE_ZERO = 2'd0,
    VOTE_ONE  = 2'd1,
    VOTE_TIE  = 2'd2
  } vote_t;
endpackage

// File: rtl/ovs_reset_sync.sv
module ovs_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ok_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_ok_n = sync_q[STAGES-1];
endmodule

// File: rtl/ovs_vote.sv
module ovs_vote
  import ovs_gearbox_pkg::*;
#(
  parameter int unsigned OSR = 4
) (
  input  logic [OSR-1:0] samples_i,
  output vote_t          vote_o
);
  localparam int unsigned CW = $clog2(OSR + 1);
  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < OSR; i++) ones = ones + CW'(samples_i[i]);
    if (2 * int'(ones) > OSR)       vote_o = VOTE_ONE;
    else if (2 * int'(ones) < OSR)  vote_o = VOTE_ZERO;
    else                            vote_o = VOTE_TIE;
  end
endmodule

// File: rtl/ovs_tx_expand.sv
module ovs_tx_expand #(
  parameter int unsigned OSR   = 4,
  parameter int unsigned LANES = 2,
  localparam int unsigned W    = OSR * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [LANES-1:0] in_bits_i,
  output logic             in_ready_o,
  output logic [W-1:0]     word_o,
  output logic             word_valid_o
);
  logic [W-1:0] word_q, word_d, expanded;
  logic         valid_q, valid_d;
  logic         take;

  assign in_ready_o = rst_n;
  assign take       = in_valid_i & in_ready_o;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign expanded[W-1-k*OSR -: OSR] = {OSR{in_bits_i[LANES-1-k]}};
  end

  always_comb begin
    word_d  = word_q;
    valid_d = 1'b0;
    if (take) begin
      word_d  = expanded;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o       = word_q;
  assign word_valid_o = valid_q;

  assert_beat_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> word_valid_o);

  assert_lane_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> (word_o[W-1 -: OSR] == {OSR{$past(in_bits_i[LANES-1])}}));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!word_valid_o && $stable(word_o)));
endmodule

// File: rtl/ovs_rx_decim.sv
module ovs_rx_decim
  import ovs_gearbox_pkg::*;
#(
  parameter int unsigned OSR   = 4,
  parameter int unsigned LANES = 2,
  parameter int unsigned TIE_W = 16,
  localparam int unsigned W    = OSR * LANES,
  localparam int unsigned PW   = $clog2(OSR),
  localparam int unsigned TW   = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [W-1:0]     in_word_i,
  input  logic [PW-1:0]    phase_i,
  output logic             out_valid_o,
  output logic [LANES-1:0] out_bits_o,
  output logic [TIE_W-1:0] tie_cnt_o
);
  logic [W-1:0]     hist_q, hist_d;
  logic             last_q, last_d;
  logic [TIE_W-1:0] tie_q, tie_d;
  logic [LANES-1:0] bits_q, bits_d, decided;
  logic             valid_q, valid_d;
  logic [2*W-1:0]   stream;
  logic [W-1:0]     window;
  logic [TW-1:0]    ties;
  vote_t            votes [LANES];

  always_comb begin
    stream = {hist_q, in_word_i};
    window = W'(stream >> phase_i);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_grp
    ovs_vote #(.OSR(OSR)) vote_i (
      .samples_i (window[W-1-k*OSR -: OSR]),
      .vote_o    (votes[k])
    );
  end

  always_comb begin
    logic carry;
    carry   = last_q;
    ties    = '0;
    decided = '0;
    for (int k = 0; k < LANES; k++) begin
      case (votes[k])
        VOTE_ONE:  decided[LANES-1-k] = 1'b1;
        VOTE_ZERO: decided[LANES-1-k] = 1'b0;
        default: begin
          decided[LANES-1-k] = carry;
          ties = ties + TW'(1);
        end
      endcase
      carry = decided[LANES-1-k];
    end
  end

  always_comb begin
    hist_d  = hist_q;
    last_d  = last_q;
    tie_d   = tie_q;
    bits_d  = bits_q;
    valid_d = 1'b0;
    if (in_valid_i) begin
      hist_d  = in_word_i;
      last_d  = decided[0];
      tie_d   = tie_q + TIE_W'(ties);
      bits_d  = decided;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      last_q  <= 1'b0;
      tie_q   <= '0;
      bits_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      last_q  <= last_d;
      tie_q   <= tie_d;
      bits_q  <= bits_d;
      valid_q <= valid_d;
    end
  end

  assign out_valid_o = valid_q;
  assign out_bits_o  = bits_q;
  assign tie_cnt_o   = tie_q;

  assert_one_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);

  assert_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!out_valid_o && $stable(hist_q) && $stable(last_q) && $stable(tie_cnt_o)));

  assert_tie_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (TIE_W'(tie_cnt_o - $past(tie_cnt_o)) <= TIE_W'(LANES)));

  assert_hist_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> (hist_q == $past(in_word_i)));
endmodule

// File: rtl/ovs_gearbox.sv
module ovs_gearbox #(
  parameter int unsigned OSR   = 4,
  parameter int unsigned LANES = 2,
  parameter int unsigned TIE_W = 16,
  localparam int unsigned W    = OSR * LANES,
  localparam int unsigned PW   = $clog2(OSR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid_i,
  input  logic [LANES-1:0] tx_bits_i,
  output logic             tx_ready_o,
  output logic [W-1:0]     tx_word_o,
  output logic             tx_word_valid_o,
  input  logic             rx_valid_i,
  input  logic [W-1:0]     rx_word_i,
  input  logic [PW-1:0]    rx_phase_i,
  output logic             rx_valid_o,
  output logic [LANES-1:0] rx_bits_o,
  output logic [TIE_W-1:0] rx_tie_cnt_o
);
  logic rst_ok_n;

  ovs_reset_sync #(.STAGES(2)) rst_i (
    .clk      (clk),
    .arst_n   (rst_n),
    .rst_ok_n (rst_ok_n)
  );

  ovs_tx_expand #(.OSR(OSR), .LANES(LANES)) tx_i (
    .clk          (clk),
    .rst_n        (rst_ok_n),
    .in_valid_i   (tx_valid_i),
    .in_bits_i    (tx_bits_i),
    .in_ready_o   (tx_ready_o),
    .word_o       (tx_word_o),
    .word_valid_o (tx_word_valid_o)
  );

  ovs_rx_decim #(.OSR(OSR), .LANES(LANES), .TIE_W(TIE_W)) rx_i (
    .clk         (clk),
    .rst_n       (rst_ok_n),
    .in_valid_i  (rx_valid_i),
    .in_word_i   (rx_word_i),
    .phase_i     (rx_phase_i),
    .out_valid_o (rx_valid_o),
    .out_bits_o  (rx_bits_o),
    .tie_cnt_o   (rx_tie_cnt_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (tx_word_o == '0 && !tx_word_valid_o && !tx_ready_o && !rx_valid_o
                && rx_tie_cnt_o == '0));
endmodule

// File: tb/ovs_gearbox_tb_top.sv
module ovs_gearbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_valid_i;
  logic [1:0]  tx_bits_i;
  logic        tx_ready_o;
  logic [7:0]  tx_word_o;
  logic        tx_word_valid_o;
  logic        rx_valid_i;
  logic [7:0]  rx_word_i;
  logic [1:0]  rx_phase_i;
  logic        rx_valid_o;
  logic [1:0]  rx_bits_o;
  logic [15:0] rx_tie_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0]  m_hist;
  logic        m_last;
  logic [15:0] m_ties;

  always #2 clk = ~clk;

  ovs_gearbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_valid_i(tx_valid_i), .tx_bits_i(tx_bits_i), .tx_ready_o(tx_ready_o),
    .tx_word_o(tx_word_o), .tx_word_valid_o(tx_word_valid_o),
    .rx_valid_i(rx_valid_i), .rx_word_i(rx_word_i), .rx_phase_i(rx_phase_i),
    .rx_valid_o(rx_valid_o), .rx_bits_o(rx_bits_o), .rx_tie_cnt_o(rx_tie_cnt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tx_valid_i = 1'b0; rx_valid_i = 1'b0;
    tx_bits_i = '0; rx_word_i = '0; rx_phase_i = '0;
    @(posedge clk); #1;
    chk("R1 tx_word zero", tx_word_o, 0);
    chk("R1 tx_word_valid low", tx_word_valid_o, 0);
    chk("R1 tx_ready low", tx_ready_o, 0);
    chk("R1 rx_valid low", rx_valid_o, 0);
    chk("R1 tie count zero", rx_tie_cnt_o, 0);
    m_hist = '0; m_last = 1'b0; m_ties = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R3 ready after reset", tx_ready_o, 1);
  endtask

  task automatic tx_beat(input logic [1:0] bits, input logic [7:0] exp, input string req);
    @(negedge clk);
    tx_valid_i = 1'b1; tx_bits_i = bits;
    @(posedge clk); #1;
    chk({req, " word"}, tx_word_o, exp);
    chk({req, " valid"}, tx_word_valid_o, 1);
    @(negedge clk);
    tx_valid_i = 1'b0;
  endtask

  task automatic tx_idle_check();
    logic [7:0] held;
    held = tx_word_o;
    @(negedge clk);
    tx_valid_i = 1'b0; tx_bits_i = 2'b10;
    @(posedge clk); #1;
    chk("R3 idle valid low", tx_word_valid_o, 0);
    chk("R3 idle word held", tx_word_o, held);
    chk("R3 ready while idle", tx_ready_o, 1);
  endtask

  task automatic rx_send(input logic [7:0] w, input logic [1:0] ph, input string req);
    logic [15:0] stream;
    logic [7:0]  win;
    logic [3:0]  g;
    logic [1:0]  exp;
    logic        carry, d;
    int          n, t;
    stream = {m_hist, w};
    win    = 8'(stream >> ph);
    carry  = m_last;
    t      = 0;
    for (int k = 0; k < 2; k++) begin
      g = win[7-4*k -: 4];
      n = $countones(g);
      if (n > 2)      d = 1'b1;
      else if (n < 2) d = 1'b0;
      else begin d = carry; t++; end
      carry = d;
      exp[1-k] = d;
    end
    @(negedge clk);
    rx_valid_i = 1'b1; rx_word_i = w; rx_phase_i = ph;
    @(posedge clk); #1;
    chk({req, " valid"}, rx_valid_o, 1);
    chk({req, " bits"}, rx_bits_o, exp);
    chk({req, " ties"}, rx_tie_cnt_o, m_ties + 16'(t));
    m_hist = w; m_last = exp[0]; m_ties = m_ties + 16'(t);
    @(negedge clk);
    rx_valid_i = 1'b0;
    @(posedge clk); #1;
    chk("R4 single pulse", rx_valid_o, 0);
  endtask

  task automatic test_tx();
    tx_beat(2'b01, 8'h0F, "R2 bits 01");
    tx_beat(2'b10, 8'hF0, "R2 bits 10");
    tx_beat(2'b11, 8'hFF, "R2 bits 11");
    tx_beat(2'b00, 8'h00, "R2 bits 00");
    tx_beat(2'b10, 8'hF0, "R2 bits 10 again");
    tx_idle_check();
  endtask

  task automatic test_rx_basic();
    rx_send(8'hF0, 2'd0, "R4 word F0");
    chk("R4 F0 gives 10", rx_bits_o, 2'b10);
    rx_send(8'h0F, 2'd0, "R4 word 0F");
    rx_send(8'hE8, 2'd0, "R5 3-of-4 and 1-of-4");
    rx_send(8'h71, 2'd0, "R5 mixed majority");
  endtask

  task automatic test_rx_ties();
    rx_send(8'hF0, 2'd0, "R6 prime last=0");
    rx_send(8'hC3, 2'd0, "R6 double tie from 0");
    rx_send(8'h0F, 2'd0, "R6 prime last=1");
    rx_send(8'hA5, 2'd0, "R6 double tie from 1");
    chk("R6 inherited 11", rx_bits_o, 2'b11);
    rx_send(8'h36, 2'd0, "R6 tie then tie");
  endtask

  task automatic test_rx_phase();
    rx_send(8'h0F, 2'd0, "R7 prime");
    rx_send(8'hC0, 2'd2, "R7 phase 2 straddle");
    rx_send(8'h87, 2'd1, "R7 phase 1");
    rx_send(8'h1E, 2'd3, "R7 phase 3");
  endtask

  task automatic test_rx_ignore();
    rx_send(8'h00, 2'd0, "R8 prime zero history");
    @(negedge clk);
    rx_valid_i = 1'b0; rx_word_i = 8'hFF; rx_phase_i = 2'd3;
    repeat (2) @(posedge clk);
    #1;
    chk("R8 no pulse", rx_valid_o, 0);
    chk("R8 ties unchanged", rx_tie_cnt_o, m_ties);
    rx_send(8'hF0, 2'd3, "R8 history kept");
    chk("R8 expected 01", rx_bits_o, 2'b01);
  endtask

  task automatic test_mid_reset();
    rx_send(8'h0F, 2'd0, "R1 prime last=1");
    rx_send(8'hC3, 2'd0, "R1 ties before reset");
    apply_reset();
    rx_send(8'hC3, 2'd0, "R1 cleared last bit");
    chk("R1 cleared gives 00", rx_bits_o, 2'b00);
    chk("R1 count from zero", rx_tie_cnt_o, 16'd2);
  endtask

  initial begin
    rst_n = 1'b0;
    tx_valid_i = 1'b0; rx_valid_i = 1'b0;
    tx_bits_i = '0; rx_word_i = '0; rx_phase_i = '0;
    apply_reset();
    test_tx();
    test_rx_basic();
    test_rx_ties();
    test_rx_phase();
    test_rx_ignore();
    test_mid_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule